// File: doc/BRIEF.md
# Serial Port with Packed Line Control

This block is a single-channel asynchronous serial port that sits on a small word-wide register bus. Software enables it through a control register, configures the whole line through one packed line register (bit-rate divisor, character size, stop bits, parity, queue depth and a break request), writes characters to a data register and reads received characters back from the same address. A status register reports queue levels, transmitter activity and three modem input levels.

Both directions are buffered by queues of up to sixteen characters. Each received character is stored with its own error tags, so a single data read gives the character and the errors found on it. Two interrupt lines, one per direction, each have their own mask bit and can be wired to separate controller inputs.

Register map (2-bit word address): 0 = control (bit 0 port enable, bit 1 transmit interrupt mask, bit 2 receive interrupt mask); 1 = line register (bits 11:0 divisor, bits 13:12 size code, bit 14 second stop bit, bit 15 parity on, bit 16 even parity, bit 17 deep queues, bit 18 break); 2 = data; 3 = status.

Top module: `lcr_uart`

## Requirements
- R1: After reset the status word reads 1 (receive queue empty, transmit queue not full, not busy, all modem bits 0), the line register reads 0x3000 (8-bit characters, divisor 0), txd is high and both interrupt lines are low.
- R2: Each bit on txd lasts exactly 16 × (divisor + 1) clock cycles. A frame is one low start bit, the data bits least significant first, an optional parity bit, then one or two high stop bits.
- R3: Size code n in bits 13:12 selects 5 + n data bits. Data bits beyond the character size are neither sent nor stored, and they read as 0 in received characters.
- R4: With bit 15 set a parity bit follows the data. With bit 16 set it makes the count of ones even, and with bit 16 clear it makes the count odd. Bit 14 set adds a second stop bit.
- R5: Reading address 2 removes the oldest received character and returns it in bits 7:0, with parity error at bit 8, framing error at bit 9 and overrun at bit 10. Bit 8 is set when the parity bit received does not match the parity configured.
- R6: The receiver samples every bit at its midpoint. A stop bit sampled low sets the framing error flag of that character.
- R7: With bit 17 set each queue holds 16 characters. With bit 17 clear each holds one. Status bit 1 (transmit full) is set at capacity, and a data write while full is dropped.
- R8: A character that completes while the receive queue is full is discarded, and the overrun flag is set on the newest character already stored.
- R9: While the break bit and the port enable are both set, txd is held low on every cycle. Clearing the break bit lets txd return high.
- R10: Status bit 2 (busy) is set while characters wait in the transmit queue or a frame is being shifted out, including all of its stop bits.
- R11: While the port enable is clear, txd stays high, queued characters are not sent, and activity on rxd adds nothing to the receive queue. Data writes are still queued.
- R12: tx_irq is high when enabled, masked in, and the transmit queue holds at most half its capacity (at most 8 deep, or empty when shallow). rx_irq is high when enabled, masked in, and the receive queue is not empty.
- R13: Status bits 3, 4 and 5 show the levels of dcd_in, dsr_in and cts_in, two clock cycles after those inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, also the bit-rate reference |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Word address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (removes a character when at address 2) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| dcd_in | input | 1 | Carrier detect level |
| dsr_in | input | 1 | Data set ready level |
| cts_in | input | 1 | Clear to send level |
| tx_irq | output | 1 | Transmit service request |
| rx_irq | output | 1 | Receive service request |

## Verification
The hardest case to reach is the overrun marking. The receive queue has to be completely full while one more whole frame arrives, and the character that already holds the newest slot has to be known. The bench gets there by queuing sixteen characters while the port is disabled, with the transmitter looped back to the receiver, and then enabling the port so all sixteen land in the receive queue. It then sends one more character and drains the queue, expecting the overrun flag only on the sixteenth entry. Errored frames cannot come from the transmitter, so they are driven bit by bit on rxd with a wrong parity bit or a low stop bit.

// File: rtl/lcr_uart_pkg.sv
// Package: line configuration type and the framing helpers that the
// serializer and the deserializer share.
package lcr_uart_pkg;

    // Frame format fields taken from the line register
    typedef struct packed {
        logic       brk;
        logic       deep;
        logic       even;
        logic       par_on;
        logic       stop2;
        logic [1:0] size;
    } line_cfg_t;

    localparam int FRAME_MAX = 12;

    // Number of data bits for a size code
    function automatic logic [3:0] data_bits(input logic [1:0] size);
        return 4'd5 + {2'b00, size};
    endfunction

    // Parity bit for the character, limited to the configured size
    function automatic logic parity_of(input logic [7:0] d, input logic [1:0] size,
                                       input logic even);
        logic [7:0] m;
        m = d & (8'hFF >> (2'd3 - size));
        return even ? ^m : ~^m;
    endfunction

    // Serial frame, LSB is sent first, unused tail positions are high
    function automatic logic [FRAME_MAX-1:0] build_frame(input logic [7:0] d,
                                                         input line_cfg_t c);
        logic [FRAME_MAX-1:0] f;
        logic [3:0] n;
        f = '1;
        f[0] = 1'b0;
        n = data_bits(c.size);
        for (int i = 0; i < 8; i++) begin
            if (4'(i) < n) f[i+1] = d[i];
        end
        if (c.par_on) f[n+4'd1] = parity_of(d, c.size, c.even);
        return f;
    endfunction

    // Total bits in a frame
    function automatic logic [3:0] frame_bits(input line_cfg_t c);
        return 4'd2 + data_bits(c.size) + {3'b000, c.par_on} + {3'b000, c.stop2};
    endfunction

endpackage

// File: rtl/lcr_uart_baud.sv
// Module: bit-rate tick generator.
// Emits one tick every (div + 1) clocks while run is high; restart clears
// the phase so a new frame starts on a full tick period.
// Assumes div is stable while a frame is in progress.
module lcr_uart_baud #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    // Count clock cycles between ticks
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) cnt <= '0;
        else if (cnt == div)           cnt <= '0;
        else                           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/lcr_uart_fifo.sv
// Module: character queue with selectable capacity.
// Holds DEPTH entries, or one when shallow is set. mark sets the top bit
// of the newest stored entry (used for overrun tagging).
// Assumes DEPTH is a power of two and mark is not raised with push.
module lcr_uart_fifo #(
    parameter int W     = 11,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shallow,
    input  logic          push,
    input  logic          pop,
    input  logic          mark,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cap;
    logic          do_push, do_pop;

    assign cap     = shallow ? CW'(1) : CW'(DEPTH);
    assign full    = count >= cap;
    assign empty   = count == '0;
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    // Pointer and occupancy tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    // Storage writes and newest-entry tagging
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
        else if (mark && !empty) mem[wr_ptr - 1'b1][W-1] <= 1'b1;
    end

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    p_push_full_dropped_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> count == $past(count));
endmodule

// File: rtl/lcr_uart_tx.sv
// Module: serializer.
// Takes one character from the transmit queue when idle and enabled,
// builds the whole frame and shifts it out at 16 ticks per bit.
// Assumes the line configuration is stable during a frame.
module lcr_uart_tx
    import lcr_uart_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    input  line_cfg_t        cfg,
    input  logic             q_empty,
    input  logic [7:0]       q_data,
    output logic             pop,
    output logic             line,
    output logic             active
);
    logic [FRAME_MAX-1:0] shift;
    logic [3:0]           left;
    logic [3:0]           sub;
    logic                 tick;

    assign pop  = en && !active && !q_empty;
    assign line = active ? shift[0] : 1'b1;

    lcr_uart_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(active), .restart(pop),
        .div(div), .tick(tick)
    );

    // Frame load and bit shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            shift  <= '1;
            left   <= '0;
            sub    <= '0;
        end else if (!en) begin
            active <= 1'b0;
        end else if (pop) begin
            active <= 1'b1;
            shift  <= build_frame(q_data, cfg);
            left   <= frame_bits(cfg);
            sub    <= '0;
        end else if (active && tick) begin
            sub <= sub + 1'b1;
            if (sub == 4'd15) begin
                shift <= {1'b1, shift[FRAME_MAX-1:1]};
                left  <= left - 1'b1;
                if (left == 4'd1) active <= 1'b0;
            end
        end
    end

    p_stop_when_disabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !active);

    p_frame_length_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> (left >= 4'd7 && left <= 4'd12));

    p_hold_between_ticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !tick) |=> $stable(shift));
endmodule

// File: rtl/lcr_uart_rx.sv
// Module: deserializer.
// Synchronizes rxd, starts on a falling edge, confirms the start bit at
// mid-bit and samples every later bit at its midpoint. Emits one word
// {overrun=0, frame error, parity error, data} at the first stop bit.
module lcr_uart_rx
    import lcr_uart_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    input  line_cfg_t        cfg,
    input  logic             rxd,
    output logic             push,
    output logic [10:0]      word
);
    logic       s1, s2, s3;
    logic       active, start, tick, perr;
    logic [3:0] idx, sub, nbits, par_idx, stop_idx;
    logic [7:0] data;

    assign start    = en && !active && s3 && !s2;
    assign nbits    = data_bits(cfg.size);
    assign par_idx  = nbits + 4'd1;
    assign stop_idx = nbits + 4'd1 + {3'b000, cfg.par_on};

    lcr_uart_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(active), .restart(start),
        .div(div), .tick(tick)
    );

    // Two-stage synchronizer plus edge history
    always_ff @(posedge clk) begin
        if (!rst_n) {s1, s2, s3} <= 3'b111;
        else        {s1, s2, s3} <= {rxd, s1, s2};
    end

    // Bit sampling and character assembly
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            idx    <= '0;
            sub    <= '0;
            data   <= '0;
            perr   <= 1'b0;
            push   <= 1'b0;
            word   <= '0;
        end else begin
            push <= 1'b0;
            if (!en) begin
                active <= 1'b0;
            end else if (start) begin
                active <= 1'b1;
                idx    <= '0;
                sub    <= '0;
                data   <= '0;
                perr   <= 1'b0;
            end else if (active && tick) begin
                sub <= sub + 1'b1;
                if (sub == 4'd15) idx <= idx + 1'b1;
                if (sub == 4'd7) begin
                    if (idx == 4'd0) begin
                        if (s2) active <= 1'b0;
                    end else if (idx <= nbits) begin
                        data[3'(idx - 4'd1)] <= s2;
                    end else if (cfg.par_on && idx == par_idx) begin
                        perr <= s2 != parity_of(data, cfg.size, cfg.even);
                    end else if (idx == stop_idx) begin
                        push   <= 1'b1;
                        word   <= {1'b0, !s2, perr, data};
                        active <= 1'b0;
                    end
                end
            end
        end
    end

    p_push_single_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !push);
endmodule

// File: rtl/lcr_uart.sv
// Module: register-mapped serial port top.
// Decodes the four bus registers, holds control and line configuration,
// joins the queues to the serializer and deserializer, and forms the
// interrupt and status outputs. Assumes one bus access per cycle.
module lcr_uart
    import lcr_uart_pkg::*;
#(
    parameter int DIV_W  = 12,
    parameter int DEPTH  = 16,
    parameter int BUS_W  = 32,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int P_SZ  = DIV_W,
    localparam int P_CFG = DIV_W + 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             rxd,
    output logic             txd,
    input  logic             dcd_in,
    input  logic             dsr_in,
    input  logic             cts_in,
    output logic             tx_irq,
    output logic             rx_irq
);
    localparam logic [1:0] A_CTRL = 2'd0, A_LINE = 2'd1, A_DATA = 2'd2, A_STAT = 2'd3;

    logic             en, tx_ie, rx_ie;
    logic [DIV_W-1:0] div;
    line_cfg_t        cfg;
    logic [2:0]       mdm_a, mdm_b;

    logic             tx_pop, tx_line, tx_active, tx_empty, tx_full;
    logic [7:0]       tx_head;
    logic [CW-1:0]    tx_count, rx_count, tx_half;
    logic             rx_push, rx_empty, rx_full;
    logic [10:0]      rx_word, rx_head;

    // Control and line register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {rx_ie, tx_ie, en} <= 3'b000;
            div                <= '0;
            cfg                <= '{size: 2'b11, default: 1'b0};
        end else if (bus_wr && bus_addr == A_CTRL) begin
            {rx_ie, tx_ie, en} <= bus_wdata[2:0];
        end else if (bus_wr && bus_addr == A_LINE) begin
            div <= bus_wdata[DIV_W-1:0];
            cfg <= bus_wdata[P_CFG-1:P_SZ];
        end
    end

    // Modem input synchronizer
    always_ff @(posedge clk) begin
        if (!rst_n) {mdm_b, mdm_a} <= '0;
        else        {mdm_b, mdm_a} <= {mdm_a, cts_in, dsr_in, dcd_in};
    end

    lcr_uart_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .shallow(!cfg.deep),
        .push(bus_wr && bus_addr == A_DATA), .pop(tx_pop), .mark(1'b0),
        .din(bus_wdata[7:0]), .dout(tx_head), .empty(tx_empty),
        .full(tx_full), .count(tx_count)
    );

    lcr_uart_tx #(.DIV_W(DIV_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .en(en), .div(div), .cfg(cfg),
        .q_empty(tx_empty), .q_data(tx_head), .pop(tx_pop),
        .line(tx_line), .active(tx_active)
    );

    lcr_uart_rx #(.DIV_W(DIV_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .en(en), .div(div), .cfg(cfg),
        .rxd(rxd), .push(rx_push), .word(rx_word)
    );

    lcr_uart_fifo #(.W(11), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .shallow(!cfg.deep),
        .push(rx_push), .pop(bus_rd && bus_addr == A_DATA),
        .mark(rx_push && rx_full), .din(rx_word), .dout(rx_head),
        .empty(rx_empty), .full(rx_full), .count(rx_count)
    );

    // Serial output with break override
    assign txd     = (en && cfg.brk) ? 1'b0 : tx_line;

    // Service requests
    assign tx_half = cfg.deep ? CW'(DEPTH / 2) : CW'(0);
    assign tx_irq  = en && tx_ie && (tx_count <= tx_half);
    assign rx_irq  = en && rx_ie && !rx_empty;

    // Register read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: bus_rdata[2:0] = {rx_ie, tx_ie, en};
            A_LINE: bus_rdata[P_CFG-1:0] = {cfg, div};
            A_DATA: bus_rdata[10:0] = rx_empty ? 11'd0 : rx_head;
            default: bus_rdata[5:0] = {mdm_b, tx_active || !tx_empty, tx_full, rx_empty};
        endcase
    end

    p_tx_irq_quiet_when_full_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full && cfg.deep) |-> !tx_irq);

    p_rx_count_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full && !(bus_rd && bus_addr == A_DATA)) |=> rx_count == $past(rx_count));
endmodule

// File: tb/lcr_uart_bench.sv
// Bench: drives the register bus, loops txd back to rxd or drives rxd
// itself, decodes txd bit by bit with a behavioural model and compares
// against frames and queue contents computed here.
module lcr_uart_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        txd, tx_irq, rx_irq;
    logic        loop = 1'b0, rx_drv = 1'b1;
    logic        dcd = 1'b0, dsr = 1'b0, cts = 1'b0;
    logic        rxd_w;
    int          checks = 0, failures = 0;
    int          word_q[$];

    always #4 clk = ~clk;
    assign rxd_w = loop ? txd : rx_drv;

    lcr_uart u_lcr_uart (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rxd(rxd_w), .txd(txd), .dcd_in(dcd), .dsr_in(dsr), .cts_in(cts),
        .tx_irq(tx_irq), .rx_irq(rx_irq)
    );

    localparam int DIV = 1;
    localparam int BITC = 16 * (DIV + 1);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_line(int sz, bit st2, bit pon, bit ev, bit deep, bit brk);
        return DIV | (sz << 12) | (st2 << 14) | (pon << 15) | (ev << 16) | (deep << 17) | (brk << 18);
    endfunction

    // Expected serial frame from the requirements
    function automatic void exp_frame(input int d, input int sz, input bit st2, input bit pon,
                                      input bit ev, output logic [15:0] b, output int n);
        int nb, ones;
        nb = 5 + sz; ones = 0; b = '1; b[0] = 1'b0;
        for (int i = 0; i < nb; i++) begin
            b[i+1] = d[i];
            ones += d[i];
        end
        n = nb + 1;
        if (pon) begin
            b[n] = ev ? (ones % 2 == 1) : (ones % 2 == 0);
            n++;
        end
        n += st2 ? 2 : 1;
    endfunction

    task automatic bus_write(input int a, input logic [31:0] v);
        @(negedge clk); bus_addr = 2'(a); bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic peek(input int a, output int v);
        @(negedge clk); bus_addr = 2'(a); #1 v = bus_rdata;
    endtask

    task automatic pop_data(output int v);
        @(negedge clk); bus_addr = 2'd2; bus_rd = 1'b1; #1 v = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    // Behavioural decoder: sample each txd bit at its centre
    task automatic capture(input string req, input int d, input int sz, input bit st2,
                           input bit pon, input bit ev);
        logic [15:0] b; int n, bad;
        exp_frame(d, sz, st2, pon, ev, b, n);
        bad = 0;
        @(negedge txd);
        repeat (BITC / 2) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            if (txd !== b[i]) bad++;
            if (i < n - 1) repeat (BITC) @(negedge clk);
        end
        chk(req, bad, 0);
    endtask

    task automatic drive_frame(input logic [15:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            rx_drv = b[i];
            repeat (BITC) @(negedge clk);
        end
        rx_drv = 1'b1;
        repeat (2 * BITC) @(negedge clk);
    endtask

    task automatic wait_idle();
        int s;
        for (int k = 0; k < 20000; k++) begin
            peek(3, s);
            if (s[2] == 1'b0) break;
        end
        repeat (BITC * 2) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int v, bad;
        logic [15:0] fb; int fn;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        peek(3, v); chk("R1 status", v, 1);
        peek(1, v); chk("R1 line", v, 32'h3000);
        chk("R1 txd", int'(txd), 1);
        chk("R1 irqs", int'({tx_irq, rx_irq}), 0);

        // R13 modem levels
        dcd = 1'b1; cts = 1'b1;
        repeat (3) @(negedge clk);
        peek(3, v); chk("R13 modem", (v >> 3) & 7, 3'b101);
        dcd = 1'b0; cts = 1'b0;

        // R2 8N1 loopback
        loop = 1'b1;
        bus_write(1, mk_line(3, 0, 0, 0, 1, 0));
        bus_write(0, 3'b111);
        @(negedge clk); chk("R12 tx_irq empty", int'(tx_irq), 1);
        chk("R12 rx_irq none", int'(rx_irq), 0);
        bus_write(2, 32'hA5);
        fork
            capture("R2 8N1 frame", 'hA5, 3, 0, 0, 0);
            begin
                repeat (BITC * 9 + BITC / 2 + 4) @(negedge clk);
                peek(3, v); chk("R10 busy in stop bit", (v >> 2) & 1, 1);
            end
        join
        repeat (BITC) @(negedge clk);
        peek(3, v); chk("R10 busy clear", (v >> 2) & 1, 0);
        chk("R12 rx_irq pending", int'(rx_irq), 1);
        pop_data(v); chk("R5 data 8N1", v, 'hA5);
        chk("R12 rx_irq cleared", int'(rx_irq), 0);

        // R3 R4 7E2
        bus_write(1, mk_line(2, 1, 1, 1, 1, 0));
        bus_write(2, 32'hDA);
        capture("R4 7E2 frame", 'h5A, 2, 1, 1, 1);
        repeat (BITC) @(negedge clk);
        pop_data(v); chk("R3 7-bit data", v, 'h5A);

        // R3 R4 5O1
        bus_write(1, mk_line(0, 0, 1, 0, 1, 0));
        bus_write(2, 32'hFF);
        capture("R4 5O1 frame", 'h1F, 0, 0, 1, 0);
        repeat (2 * BITC) @(negedge clk);
        pop_data(v); chk("R3 5-bit data", v, 'h1F);

        // R5 parity error on driven input (8E1)
        loop = 1'b0;
        bus_write(1, mk_line(3, 0, 1, 1, 1, 0));
        exp_frame('h3C, 3, 0, 1, 1, fb, fn);
        fb[9] = ~fb[9];
        drive_frame(fb, fn);
        pop_data(v); chk("R5 parity flag", v, 'h13C);

        // R6 framing error (8N1, low stop bit)
        bus_write(1, mk_line(3, 0, 0, 0, 1, 0));
        exp_frame('h81, 3, 0, 0, 0, fb, fn);
        fb[9] = 1'b0;
        drive_frame(fb, fn);
        pop_data(v); chk("R6 frame flag", v, 'h281);

        // R11 receive ignored while disabled
        bus_write(0, 3'b110);
        exp_frame('h3C, 3, 0, 0, 0, fb, fn);
        drive_frame(fb, fn);
        bus_write(0, 3'b111);
        peek(3, v); chk("R11 rx ignored", v & 1, 1);

        // R7 R8 deep queues and overrun
        bus_write(0, 3'b110);
        for (int i = 0; i < 16; i++) bus_write(2, 32'h10 + i);
        peek(3, v); chk("R7 tx full deep", (v >> 1) & 1, 1);
        bus_write(2, 32'h99);
        loop = 1'b1;
        bus_write(0, 3'b111);
        @(negedge clk); chk("R12 tx_irq above half", int'(tx_irq), 0);
        wait_idle();
        chk("R12 tx_irq drained", int'(tx_irq), 1);
        bus_write(2, 32'h77);
        wait_idle();
        for (int i = 0; i < 16; i++) word_q.push_back(i == 15 ? 'h41F : 'h10 + i);
        bad = 0;
        for (int i = 0; i < 16; i++) begin
            int e;
            pop_data(v);
            e = word_q.pop_front();
            if (v != e) bad++;
        end
        chk("R8 overrun on newest", bad, 0);
        peek(3, v); chk("R7 rx empty after 16", v & 1, 1);

        // R7 R11 shallow queues, disabled line stays high
        bus_write(0, 3'b000);
        bus_write(1, mk_line(3, 0, 0, 0, 0, 0));
        bus_write(2, 32'h33);
        peek(3, v); chk("R7 tx full shallow", (v >> 1) & 1, 1);
        bus_write(2, 32'h44);
        bad = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) bad++;
        end
        chk("R11 txd idle disabled", bad, 0);
        bus_write(0, 3'b101);
        @(negedge clk); chk("R12 tx mask", int'(tx_irq), 0);
        wait_idle();
        pop_data(v); chk("R7 shallow first kept", v, 'h33);
        peek(3, v); chk("R7 second dropped", v & 1, 1);

        // R9 break
        bus_write(1, mk_line(3, 0, 0, 0, 0, 1));
        repeat (2) @(negedge clk);
        bad = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (txd !== 1'b0) bad++;
        end
        chk("R9 break low", bad, 0);
        bus_write(1, mk_line(3, 0, 0, 0, 0, 0));
        repeat (2) @(negedge clk);
        chk("R9 break released", int'(txd), 1);
        repeat (4 * BITC) @(negedge clk);
        peek(3, v); chk("R9 no spurious rx", v & 1, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule